// File: doc/BRIEF.md
# Burst Beat Address and Strobe Sequencer

This block accepts a single write-address request made of a start address, a beat-count field, a transfer size and a burst type. It then walks the burst one beat at a time. For every beat it presents the byte address and the byte-lane enable mask for a data bus that is `BUS_BYTES` wide. A consumer takes a beat by completing a step handshake. A last flag marks the final beat of the burst.

When the request is accepted, the block also judges whether it is legal. It raises one flag for an incrementing burst whose final address falls in a different 4 KB page from its start. It raises a second flag for a wrapping burst whose start address is not aligned to the transfer size, or whose beat count is not a power of two between 2 and 16. Both flags are registered when the request is accepted. A flagged burst is still walked in full, so the logic downstream can decide what to do with it.

An unaligned start address is handled with partial lane masks. The first beat of an incrementing burst enables only the lanes from the start byte up to the top of its size-aligned container. Every beat of a fixed burst repeats that same partial mask.

Top module: `burst_seq`

## Requirements
- R1: After reset, `reqReady` is 1, `beatValid` is 0 and both error flags are 0. `reqReady` is 1 exactly when no burst is in progress. A request is accepted on a clock edge where `reqValid` and `reqReady` are both 1, and `beatValid` is 1 from the next cycle on.
- R2: While `beatValid` is 1 and `beatReady` is 0, `beatAddr`, `beatStrb` and `beatLast` keep their values into the next cycle.
- R3: Beats are numbered from 0. `beatLast` is 1 only on beat number `reqLen`, which gives `reqLen`+1 beats in all. A step on the last beat returns the block to idle in the next cycle.
- R4: Burst type 1 is incrementing. Beat 0 uses the start address unchanged. Beat k>0 uses the start address rounded down to a multiple of 2^size, plus k·2^size.
- R5: Burst type 0 is fixed. Every beat repeats the original start address, which may be unaligned, and the same lane mask.
- R6: Burst type 2 is wrapping. The region size is (reqLen+1)·2^size and the region base is the start address rounded down to that size. Beat k uses start + k·2^size, reduced by the region size once the sum reaches the top of the region.
- R7: Lane i of `beatStrb` is 1 exactly when i lies in the 2^size-byte aligned container that holds lane (beatAddr mod `BUS_BYTES`), and i is not below that lane. For example, start 4095 with size 1 and reqLen 0 gives the strobe 0x80 on an 8-byte bus.
- R8: `errPage` is 1 for an incrementing burst when bits 12 and up of (start + (reqLen << size)) differ from bits 12 and up of the start address. It is never set for the other burst types. Start 4095 with size 1 and reqLen 0 does not set it.
- R9: `errWrap` is 1 for a wrapping burst whose start address is not a multiple of 2^size, or whose reqLen is not 1, 3, 7 or 15. It is never set for the other burst types.
- R10: Both error flags take their values when a request is accepted and hold them until the next acceptance. A wrapping burst that sets `errWrap` is still walked for reqLen+1 beats, using the incrementing address rule.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | A request is offered |
| reqReady | output | 1 | The block is idle and can accept a request |
| reqAddr | input | ADDR_W | Start byte address |
| reqLen | input | LEN_W | Beat count minus one |
| reqSize | input | SIZE_W | log2 of the bytes per beat, at most log2(BUS_BYTES) |
| reqBurst | input | 2 | Burst type: 0 fixed, 1 incrementing, 2 wrapping |
| beatValid | output | 1 | A beat is being presented |
| beatReady | input | 1 | The consumer takes the current beat |
| beatAddr | output | ADDR_W | Byte address of the current beat |
| beatStrb | output | BUS_BYTES | Byte-lane enables of the current beat |
| beatLast | output | 1 | The current beat is the final one |
| errPage | output | 1 | The incrementing burst crosses a 4 KB page |
| errWrap | output | 1 | The wrapping burst is illegal |

## Verification
On every cycle, the assertions check the handshake behaviour:
- an accepted request is followed by a presented beat;
- a stalled beat holds steady;
- a step on the last beat returns the block to idle;
- the error flags do not move during a burst;
- the later beats of an incrementing burst are size-aligned.

Only the bench scenarios can show that the address sequences, lane masks and error decisions are correct. The bench compares them against its own models over random bursts of every type. It also runs directed corners: the single-byte beat at the top of a page, a burst that crosses a page, a wrap that turns around, an unaligned wrap and an unaligned fixed burst.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  typedef enum logic [1:0] {
    BURST_FIXED = 2'd0,
    BURST_INCR  = 2'd1,
    BURST_WRAP  = 2'd2
  } burst_e;

  typedef struct packed {
    logic load;
    logic step;
  } seqCtrl_t;
endpackage

// File: rtl/burst_seq_ctrl.sv
module burst_seq_ctrl
  import burst_seq_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     reqValid,
  input  logic     beatReady,
  input  logic     lastBeat,
  output logic     reqReady,
  output logic     beatValid,
  output seqCtrl_t ctrl
);
  logic busyR;

  assign reqReady  = !busyR;
  assign beatValid = busyR;
  assign ctrl.load = reqValid && !busyR;
  assign ctrl.step = busyR && beatReady;

  always_ff @(posedge clk) begin
    if (!rstN)                       busyR <= 1'b0;
    else if (ctrl.load)              busyR <= 1'b1;
    else if (ctrl.step && lastBeat)  busyR <= 1'b0;
  end

  // R1
  accept_to_beat_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> beatValid);

  // R3
  last_to_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (beatValid && beatReady && lastBeat) |=> (!beatValid && reqReady));
endmodule

// File: rtl/burst_seq_dp.sv
module burst_seq_dp
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int LEN_W     = 8,
  parameter int SIZE_W    = 3,
  parameter int BUS_BYTES = 8,
  parameter int PAGE_BITS = 12
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  seqCtrl_t             ctrl,
  input  logic [ADDR_W-1:0]    reqAddr,
  input  logic [LEN_W-1:0]     reqLen,
  input  logic [SIZE_W-1:0]    reqSize,
  input  logic [1:0]           reqBurst,
  output logic [ADDR_W-1:0]    beatAddr,
  output logic [BUS_BYTES-1:0] beatStrb,
  output logic                 lastBeat,
  output logic                 errPage,
  output logic                 errWrap
);
  localparam int LANE_W = (BUS_BYTES > 1) ? $clog2(BUS_BYTES) : 1;

  logic [ADDR_W-1:0] startR;
  logic [LEN_W-1:0]  lenR, idxR;
  logic [SIZE_W-1:0] sizeR;
  logic [1:0]        burstR;
  logic              errPageR, errWrapR;

  // Legality of the incoming request
  logic [ADDR_W-1:0] inSizeBytes, inEnd;
  logic              inLenPow2, pageBad, wrapBad;
  always_comb begin
    inSizeBytes = ADDR_W'(1) << reqSize;
    inEnd       = reqAddr + (ADDR_W'(reqLen) << reqSize);
    inLenPow2   = (reqLen == LEN_W'(1)) || (reqLen == LEN_W'(3)) ||
                  (reqLen == LEN_W'(7)) || (reqLen == LEN_W'(15));
    pageBad     = (reqBurst == BURST_INCR) &&
                  (inEnd[ADDR_W-1:PAGE_BITS] != reqAddr[ADDR_W-1:PAGE_BITS]);
    wrapBad     = (reqBurst == BURST_WRAP) &&
                  (((reqAddr & (inSizeBytes - ADDR_W'(1))) != '0) || !inLenPow2);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      startR   <= '0;
      lenR     <= '0;
      idxR     <= '0;
      sizeR    <= '0;
      burstR   <= '0;
      errPageR <= 1'b0;
      errWrapR <= 1'b0;
    end else if (ctrl.load) begin
      startR   <= reqAddr;
      lenR     <= reqLen;
      idxR     <= '0;
      sizeR    <= reqSize;
      burstR   <= reqBurst;
      errPageR <= pageBad;
      errWrapR <= wrapBad;
    end else if (ctrl.step) begin
      idxR     <= idxR + LEN_W'(1);
    end
  end

  // Beat address
  logic [ADDR_W-1:0] sizeBytes, offs, incrAddr, wrapTotal, wrapMask, wrapAddr;
  always_comb begin
    sizeBytes = ADDR_W'(1) << sizeR;
    offs      = ADDR_W'(idxR) << sizeR;
    incrAddr  = (idxR == '0) ? startR
                             : (startR & ~(sizeBytes - ADDR_W'(1))) + offs;
    wrapTotal = (ADDR_W'(lenR) + ADDR_W'(1)) << sizeR;
    wrapMask  = wrapTotal - ADDR_W'(1);
    wrapAddr  = (startR & ~wrapMask) | ((startR + offs) & wrapMask);
    case (burstR)
      BURST_FIXED: beatAddr = startR;
      BURST_WRAP:  beatAddr = errWrapR ? incrAddr : wrapAddr;
      default:     beatAddr = incrAddr;
    endcase
  end

  // Lane mask: the aligned container holding the address lane, cut below it
  logic [LANE_W-1:0] lane;
  always_comb begin
    lane = beatAddr[LANE_W-1:0];
    for (int i = 0; i < BUS_BYTES; i++) begin
      beatStrb[i] = (i >= int'(lane)) && ((i >> sizeR) == (int'(lane) >> sizeR));
    end
  end

  assign lastBeat = (idxR == lenR);
  assign errPage  = errPageR;
  assign errWrap  = errWrapR;

  // R4
  incr_align_chk: assert property (@(posedge clk) disable iff (!rstN)
    (burstR == BURST_INCR && idxR != '0) |-> ((beatAddr & (sizeBytes - ADDR_W'(1))) == '0));
endmodule

// File: rtl/burst_seq.sv
module burst_seq
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int LEN_W     = 8,
  parameter int SIZE_W    = 3,
  parameter int BUS_BYTES = 8,
  parameter int PAGE_BITS = 12
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 reqValid,
  output logic                 reqReady,
  input  logic [ADDR_W-1:0]    reqAddr,
  input  logic [LEN_W-1:0]     reqLen,
  input  logic [SIZE_W-1:0]    reqSize,
  input  logic [1:0]           reqBurst,
  output logic                 beatValid,
  input  logic                 beatReady,
  output logic [ADDR_W-1:0]    beatAddr,
  output logic [BUS_BYTES-1:0] beatStrb,
  output logic                 beatLast,
  output logic                 errPage,
  output logic                 errWrap
);
  seqCtrl_t ctrl;
  logic     lastBeat;

  burst_seq_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .beatReady(beatReady),
    .lastBeat(lastBeat), .reqReady(reqReady), .beatValid(beatValid), .ctrl(ctrl)
  );

  burst_seq_dp #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .SIZE_W(SIZE_W),
    .BUS_BYTES(BUS_BYTES), .PAGE_BITS(PAGE_BITS)
  ) dp_i (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .reqAddr(reqAddr), .reqLen(reqLen),
    .reqSize(reqSize), .reqBurst(reqBurst), .beatAddr(beatAddr),
    .beatStrb(beatStrb), .lastBeat(lastBeat), .errPage(errPage), .errWrap(errWrap)
  );

  assign beatLast = lastBeat && beatValid;

  // R2
  hold_beat_chk: assert property (@(posedge clk) disable iff (!rstN)
    (beatValid && !beatReady) |=> ($stable(beatAddr) && $stable(beatStrb) && $stable(beatLast)));

  // R10
  err_steady_chk: assert property (@(posedge clk) disable iff (!rstN)
    (beatValid && $past(beatValid)) |-> ($stable(errPage) && $stable(errWrap)));
endmodule

// File: tb/burst_seq_tb.sv
module burst_seq_tb_top;
  localparam int AW = 32;
  localparam int BB = 8;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          reqValid = 1'b0;
  logic          reqReady;
  logic [AW-1:0] reqAddr = '0;
  logic [7:0]    reqLen = '0;
  logic [2:0]    reqSize = '0;
  logic [1:0]    reqBurst = '0;
  logic          beatValid;
  logic          beatReady = 1'b0;
  logic [AW-1:0] beatAddr;
  logic [BB-1:0] beatStrb;
  logic          beatLast;
  logic          errPage, errWrap;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  burst_seq dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqAddr(reqAddr), .reqLen(reqLen), .reqSize(reqSize), .reqBurst(reqBurst),
    .beatValid(beatValid), .beatReady(beatReady), .beatAddr(beatAddr),
    .beatStrb(beatStrb), .beatLast(beatLast), .errPage(errPage), .errWrap(errWrap)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit expPage(input logic [AW-1:0] a, input int len, input int sz, input int bt);
    logic [AW-1:0] e;
    e = a + AW'(len * (1 << sz));
    return (bt == 1) && ((e >> 12) != (a >> 12));
  endfunction

  function automatic bit expWrap(input logic [AW-1:0] a, input int len, input int sz, input int bt);
    bit lenOk;
    lenOk = (len == 1) || (len == 3) || (len == 7) || (len == 15);
    return (bt == 2) && (((a % (1 << sz)) != 0) || !lenOk);
  endfunction

  function automatic logic [AW-1:0] expAddr(input logic [AW-1:0] a, input int len,
                                            input int sz, input int bt, input int k);
    logic [AW-1:0] step, tot, lo, v;
    step = AW'(1 << sz);
    if (bt == 0) return a;
    if (bt == 2 && !expWrap(a, len, sz, bt)) begin
      tot = AW'((len + 1) * (1 << sz));
      lo  = (a / tot) * tot;
      v   = a + AW'(k) * step;
      if (v >= lo + tot) v = v - tot;
      return v;
    end
    if (k == 0) return a;
    return (a / step) * step + AW'(k) * step;
  endfunction

  function automatic logic [BB-1:0] expStrb(input logic [AW-1:0] ad, input int sz);
    logic [BB-1:0] s;
    int ln, base, w;
    ln = int'(ad % BB);
    w = 1 << sz;
    base = (ln / w) * w;
    for (int i = 0; i < BB; i++) s[i] = (i >= ln) && (i < base + w);
    return s;
  endfunction

  task automatic runReq(input logic [AW-1:0] a, input int len, input int sz, input int bt);
    int k;
    bit rdy;
    logic [AW-1:0] ea;
    @(negedge clk);
    chk(reqReady == 1'b1, "R1 ready when idle", reqReady, 1);
    reqValid = 1'b1; reqAddr = a; reqLen = 8'(len); reqSize = 3'(sz); reqBurst = 2'(bt);
    @(negedge clk);
    reqValid = 1'b0;
    chk(beatValid == 1'b1, "R1 beat after accept", beatValid, 1);
    chk(errPage == expPage(a, len, sz, bt), "R8 page flag", errPage, expPage(a, len, sz, bt));
    chk(errWrap == expWrap(a, len, sz, bt), "R9 wrap flag", errWrap, expWrap(a, len, sz, bt));
    k = 0;
    while (k <= len) begin
      ea = expAddr(a, len, sz, bt, k);
      chk(beatValid == 1'b1, "R3 beat count", beatValid, 1);
      chk(reqReady == 1'b0, "R1 busy not ready", reqReady, 0);
      chk(beatAddr == ea, (bt == 0) ? "R5 fixed addr" : (bt == 2) ? "R6 wrap addr" : "R4 incr addr",
          beatAddr, ea);
      chk(beatStrb == expStrb(ea, sz), "R7 strobe", beatStrb, expStrb(ea, sz));
      chk(beatLast == (k == len), "R3 last flag", beatLast, (k == len));
      chk(errPage == expPage(a, len, sz, bt) && errWrap == expWrap(a, len, sz, bt),
          "R10 flags held", {errPage, errWrap}, {expPage(a, len, sz, bt), expWrap(a, len, sz, bt)});
      rdy = ($urandom % 4) != 0;
      beatReady = rdy;
      @(negedge clk);
      beatReady = 1'b0;
      if (rdy) k++;
      else chk(beatAddr == ea, "R2 stall hold", beatAddr, ea);
    end
    chk(beatValid == 1'b0 && reqReady == 1'b1, "R3 idle after last", beatValid, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int bt, sz, len;
    logic [AW-1:0] a;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    chk(reqReady == 1'b1 && beatValid == 1'b0, "R1 reset state", {reqReady, beatValid}, 2'b10);
    chk(errPage == 1'b0 && errWrap == 1'b0, "R1 reset flags", {errPage, errWrap}, 0);
    rstN = 1'b1;
    // R7 R8: single byte at the top of a page, no violation
    runReq(32'd4095, 0, 1, 1);
    chk(1'b1, "R7 top-of-page strobe", 0, 0);
    // R8: crossing a page
    runReq(32'd4088, 1, 3, 1);
    // R6: wrap turning around
    runReq(32'h1C, 3, 2, 2);
    // R9: unaligned wrap, and a wrap with an illegal length walked as incr (R10)
    runReq(32'h1D, 3, 2, 2);
    runReq(32'h40, 2, 1, 2);
    // R5: unaligned fixed
    runReq(32'h103, 2, 2, 0);
    // R4: unaligned incr
    runReq(32'h205, 4, 2, 1);
    for (int n = 0; n < 200; n++) begin
      bt  = $urandom % 3;
      sz  = $urandom % 4;
      len = (bt == 2 && ($urandom % 4) != 0) ? ((1 << ($urandom % 4 + 1)) - 1) : $urandom % 16;
      a   = $urandom;
      if (($urandom % 4) == 0) a = {a[AW-1:12], 12'hFF0 | 12'(a[3:0])};
      if (bt == 2 && ($urandom % 4) != 0) a = (a >> sz) << sz;
      runReq(a, len, sz, bt);
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule